// File: doc/BRIEF.md
# Linked-List Summing Walker

This block adds up the signed 8-bit integers held in a singly linked list stored in a byte-wide memory. Every node takes two consecutive bytes: the byte at the node's own address is the pointer to the following node, and the byte one address above it is the node's integer. The walk always begins with the node at address 0. A pointer equal to zero marks the final node. The list has at least one node.

The block drives an address onto the memory and reads the returned byte in the same cycle, because the memory read is asynchronous. It never issues more than one read per cycle. Each node takes exactly two cycles. In the accumulate cycle, the walker reads the value through a value-address register and adds it to the running total. In the fetch cycle, it reads the pointer, then loads that pointer together with the pointer plus one. Because the value address is computed during the fetch cycle, the accumulate cycle contains only one adder.

A one-cycle pulse on `start` launches a walk. When the walk ends, `done` goes high and `result` holds the total. Both stay unchanged until the next `start`.

Top module: `list_sum_walker`

## Requirements
- R1: While reset is active and after it is released, the walker is idle and `done` is low. No walk begins until `start` is seen.
- R2: In the cycle after `start` is sampled high, the walker is in an accumulate cycle with the pointer at 0 and the value address at 1, so `mem_addr` is 1. The total is cleared to 0 and `done` is low.
- R3: For a node at address p, `mem_addr` is p+1 in the accumulate cycle and p in the following fetch cycle.
- R4: Each node takes exactly two clock cycles. For a list of n nodes, `done` first reads high 2n clock edges after the edge that samples `start`, and it is low before that.
- R5: The walk ends after the value of the node whose pointer byte is 0 has been added. Every node before it continues the walk at the address held in its pointer byte.
- R6: `result` equals the sum of all node values, taken as two's complement and reduced modulo 256. On overflow it wraps and does not saturate.
- R7: Once `done` is high, `done` and `result` stay unchanged for every cycle until `start` is asserted again.
- R8: `start` has priority in every state. Asserting it in the middle of a walk, or after a finished walk, discards that walk and begins a fresh one as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a new walk from address 0 |
| done | output | 1 | High once the walk has finished |
| result | output | 8 | Running total; the final sum while `done` is high |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Byte read from `mem_addr` in the same cycle |

## Verification
The walk is run on lists of several shapes: a single node, short chains with positive values, chains with negative values, a chain whose total overflows, a chain whose addresses run downward and wrap through the top of memory, and a long chain of one hundred nodes. Comparing single-node lists with longer ones shows whether the zero-pointer test is applied to the right byte. Downward chains show whether the walker really follows the pointers or just steps through addresses. The address trace shows whether the value and pointer reads are in the right order, and the cycle count on each list shows whether every node costs exactly two cycles. Restarts in the middle of a walk and after a finished walk show that `start` discards the old total.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FETCH = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_t;

  // Address of the value byte that belongs to a node whose link byte is at ptr.
  function automatic logic [7:0] value_addr_of(input logic [7:0] ptr);
    return ptr + 8'd1;
  endfunction

  // Running total update: plain modulo-2^8 addition of two's complement bytes.
  function automatic logic [7:0] accumulate(input logic [7:0] acc, input logic [7:0] val);
    return acc + val;
  endfunction

endpackage

// File: rtl/lsw_zero_det.sv
module lsw_zero_det #(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  output logic         is_zero
);
  localparam int HALF = W / 2;

  logic [1:0] part_zero;

  generate
    if (W >= 2) begin : g_split
      assign part_zero[0] = ~|word[HALF-1:0];
      assign part_zero[1] = ~|word[W-1:HALF];
    end else begin : g_single
      assign part_zero[0] = ~word[0];
      assign part_zero[1] = 1'b1;
    end
  endgenerate

  assign is_zero = &part_zero;
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic link_zero,
  output logic init,
  output logic ld_sum,
  output logic ld_link,
  output logic sel_value_addr,
  output logic accum_phase,
  output logic fetch_phase,
  output logic walk_done
);
  walk_state_t state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_ACCUM;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_IDLE;
        ST_ACCUM: state_d = ST_FETCH;
        ST_FETCH: state_d = link_zero ? ST_DONE : ST_ACCUM;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign accum_phase    = (state_q == ST_ACCUM);
  assign fetch_phase    = (state_q == ST_FETCH);
  assign walk_done      = (state_q == ST_DONE);
  assign init           = start;
  assign ld_sum         = accum_phase & ~start;
  assign ld_link        = fetch_phase & ~start;
  assign sel_value_addr = accum_phase;
endmodule

// File: rtl/lsw_datapath.sv
module lsw_datapath
  import lsw_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         ld_sum,
  input  logic         ld_link,
  input  logic         sel_value_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] sum_q,
  output logic         link_zero
);
  localparam logic [W-1:0] HEAD_ADDR  = '0;
  localparam logic [W-1:0] FIRST_VADR = W'(1);

  logic [W-1:0] link_q;
  logic [W-1:0] vadr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= HEAD_ADDR;
      vadr_q <= FIRST_VADR;
      sum_q  <= '0;
    end else if (init) begin
      link_q <= HEAD_ADDR;
      vadr_q <= FIRST_VADR;
      sum_q  <= '0;
    end else begin
      if (ld_sum) sum_q <= W'(accumulate(8'(sum_q), 8'(mem_rdata)));
      if (ld_link) begin
        link_q <= mem_rdata;
        vadr_q <= W'(value_addr_of(8'(mem_rdata)));
      end
    end
  end

  assign mem_addr = sel_value_addr ? vadr_q : link_q;

  lsw_zero_det #(.W(W)) u_zero (
    .word    (mem_rdata),
    .is_zero (link_zero)
  );
endmodule

// File: rtl/list_sum_walker.sv
module list_sum_walker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         done,
  output logic [W-1:0] result,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata
);
  logic init, ld_sum, ld_link, sel_value_addr;
  logic accum_phase, fetch_phase, walk_done, link_zero;
  logic [W-1:0] sum_q;

  lsw_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .link_zero      (link_zero),
    .init           (init),
    .ld_sum         (ld_sum),
    .ld_link        (ld_link),
    .sel_value_addr (sel_value_addr),
    .accum_phase    (accum_phase),
    .fetch_phase    (fetch_phase),
    .walk_done      (walk_done)
  );

  lsw_datapath #(.W(W)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .init           (init),
    .ld_sum         (ld_sum),
    .ld_link        (ld_link),
    .sel_value_addr (sel_value_addr),
    .mem_rdata      (mem_rdata),
    .mem_addr       (mem_addr),
    .sum_q          (sum_q),
    .link_zero      (link_zero)
  );

  assign done   = walk_done;
  assign result = sum_q;
endmodule

// File: rtl/lsw_checker.sv
module lsw_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [W-1:0] result,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_rdata,
  input logic         accum_phase,
  input logic         fetch_phase,
  input logic         link_zero
);
  always_comb begin
    if (!rst_n) p_idle_in_reset_r1: assert (!done);
  end

  p_phases_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accum_phase, fetch_phase, done}));

  p_start_opens_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (accum_phase && !done && mem_addr == W'(1) && result == '0));

  p_fetch_below_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_phase |-> ((mem_addr + W'(1)) == $past(mem_addr)));

  p_accum_then_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accum_phase && !start) |=> fetch_phase);

  p_link_continues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_phase && !start && !link_zero) |=> (accum_phase && mem_addr == $past(mem_rdata) + W'(1)));

  p_null_link_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_phase && !start && link_zero) |=> done);

  p_wrap_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accum_phase && !start) |=> (result == $past(result) + $past(mem_rdata)));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  p_start_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (fetch_phase || done)) |=> accum_phase);
endmodule

bind list_sum_walker lsw_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .result      (result),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .accum_phase (accum_phase),
  .fetch_phase (fetch_phase),
  .link_zero   (link_zero)
);

// File: tb/list_sum_walker_test.sv
module list_sum_walker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       done;
  logic [7:0] result, mem_addr, mem_rdata;
  logic [7:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  list_sum_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .result(result), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  // Table: node count, address stride between nodes, first value, value step.
  localparam int NCASE = 6;
  localparam int T_N [NCASE]  = '{1, 4, 5, 4, 20, 100};
  localparam int T_ST[NCASE]  = '{2, 2, 6, 8, 250, 2};
  localparam int T_V0[NCASE]  = '{5, 10, -3, 100, -128, 1};
  localparam int T_DV[NCASE]  = '{0, 3, -7, 0, 17, 1};

  logic [7:0] exp_sum;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_list(input int n, input int stride, input int v0, input int dv);
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;
    exp_sum = 8'd0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] p, nx, v;
      p  = 8'(i * stride);
      nx = (i == n - 1) ? 8'd0 : 8'(p + 8'(stride));
      v  = 8'(v0 + i * dv);
      mem[p]        = nx;
      mem[8'(p + 1)] = v;
      exp_sum       = exp_sum + v;
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // After pulse_start returns, one edge has passed; walks the node chain
  // checking the address trace and that done stays low until edge 2n.
  task automatic walk_and_check(input int n, input int stride);
    bit addr_ok = 1'b1;
    bit early   = 1'b0;
    int bad_a = 0, exp_a = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] p;
      p = 8'(i * stride);
      if (mem_addr != 8'(p + 1) && addr_ok) begin addr_ok = 0; bad_a = mem_addr; exp_a = 8'(p + 1); end
      if (done) early = 1'b1;
      @(negedge clk);
      if (mem_addr != p && addr_ok) begin addr_ok = 0; bad_a = mem_addr; exp_a = p; end
      if (done) early = 1'b1;
      @(negedge clk);
    end
    check(addr_ok, "R3", "value/link address trace", bad_a, exp_a);
    check(!early, "R4", "done low before 2n edges", early, 0);
    check(done == 1'b1, "R4", "done after 2n edges", done, 1);
    check(result == exp_sum, "R6", "wrapped total", result, exp_sum);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    #1;
    check(done == 1'b0, "R1", "done during reset", done, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "idle after reset without start", done, 0);

    // Table-driven walks (R5 via single-node and multi-node chains).
    for (int k = 0; k < NCASE; k++) begin
      build_list(T_N[k], T_ST[k], T_V0[k], T_DV[k]);
      pulse_start();
      check(mem_addr == 8'd1 && result == 8'd0 && !done, "R2", "first cycle address", mem_addr, 1);
      walk_and_check(T_N[k], T_ST[k]);
      check(done && result == exp_sum, "R5", "walk ended at null link", result, exp_sum);
      begin
        logic [7:0] held;
        held = result;
        mem[8'd1] = 8'h7F;
        repeat (4) @(negedge clk);
        check(done && result == held, "R7", "done and result held", result, held);
      end
    end

    // Restart mid-walk (R8): long list, interrupt after 7 edges.
    build_list(100, 2, 3, 5);
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    check(mem_addr == 8'd1 && result == 8'd0 && !done, "R8", "mid-walk restart address", mem_addr, 1);
    walk_and_check(100, 2);
    check(result == exp_sum, "R8", "total after mid-walk restart", result, exp_sum);

    // Restart from done (R8) on a different list.
    build_list(3, 4, -50, -60);
    pulse_start();
    check(!done && mem_addr == 8'd1, "R8", "done cleared by start", done, 0);
    walk_and_check(3, 4);

    // Start held for several cycles keeps restarting (R8).
    build_list(2, 2, 7, 1);
    start = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_addr == 8'd1 && !done, "R8", "held start stays at head", mem_addr, 1);
    start = 1'b0;
    @(negedge clk);
    check(mem_addr == 8'd0, "R3", "link fetch after held start", mem_addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule